// File: doc/BRIEF.md
# Block Cipher Packet Sequencer

This controller walks a block-cipher core through one packet of data blocks. A packet begins with a start strobe taken while the controller is idle. At that moment it captures the packet's settings: a mode bit that chooses between a chained, authenticated mode and plain electronic-codebook operation, a direction bit that chooses encryption or decryption, and a 5-bit count of the blocks to process. If a new-key request is present, the controller first has the core load an external key. It then issues one core start per block and waits for the core's ready before it moves on.

The controller keeps a down-counter of the blocks still to be processed. It also keeps a 12-bit count of completed packages, which stops at 4095, the largest packet number a wireless link uses. When the last block finishes, a one-cycle done pulse completes the handshake. The offset and checksum arithmetic of the chained mode is not part of this block. The controller only passes the latched mode and direction to the core.

Top module: `cipher_seq_ctrl`

## Requirements
- R1: Reset is synchronous and active high. After reset the controller is idle (busy 0), blocks_left is 0, pkt_count is 0, and done, core_go and core_key_load are 0.
- R2: start is acted on only while busy is 0. A start seen while busy is 1 does not change blocks_left, the latched settings or the number of core starts.
- R3: At an accepted start, chain_mode (1 = chained authenticated, 0 = electronic codebook) and encrypt (1 = encrypt, 0 = decrypt) are latched onto core_chain and core_encrypt. These outputs stay stable for as long as busy is 1.
- R4: If key_req is 1 at an accepted start with a non-zero count, core_key_load pulses high for exactly one cycle. No core_go occurs until a core_ready has followed that pulse.
- R5: For a count N greater than 0, exactly N core_go pulses are issued, each one cycle wide. Each pulse after the first comes only after a core_ready.
- R6: blocks_left takes the count at start and drops by one on each core_ready received while waiting on a block. When the i-th core_go (counting from 0) is high, blocks_left equals N minus i.
- R7: done is high for exactly one cycle, the cycle after the core_ready of the final block. busy is 0 in that cycle and blocks_left is 0.
- R8: pkt_count rises by one with every done pulse, saturates at 4095, and does not change at any other time.
- R9: A count of 0 at start raises done in the next cycle, with no core_go and no core_key_load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Begin a packet (taken only while idle) |
| chain_mode | input | 1 | 1 = chained authenticated mode, 0 = codebook |
| encrypt | input | 1 | 1 = encrypt, 0 = decrypt |
| blk_count | input | 5 | Number of blocks in the packet |
| key_req | input | 1 | Load an external key before the blocks |
| core_ready | input | 1 | Core has finished the current operation |
| core_go | output | 1 | One-cycle start of one block on the core |
| core_key_load | output | 1 | One-cycle key-load command to the core |
| core_chain | output | 1 | Latched mode presented to the core |
| core_encrypt | output | 1 | Latched direction presented to the core |
| blocks_left | output | 5 | Blocks still to be processed |
| pkt_count | output | 12 | Completed packages, saturating at 4095 |
| busy | output | 1 | A packet is in progress |
| done | output | 1 | One-cycle packet completion pulse |

## Verification
The assertions assume that core_ready arrives only as a reply to a core_go or core_key_load, never while the controller waits on nothing, and that reset is held for at least two cycles. The bench meets the first assumption with a core model of fixed latency that raises ready only a set number of cycles after a command. It randomizes only the packet settings and the timing of stray start strobes. Packet lengths are drawn across the full range from 0 to 31, and thousands of zero-length packets push the package count up to its saturation point and past it.

// File: rtl/cipher_seq_ctrl.sv
module cipher_seq_ctrl #(
  parameter int LEN_W = 5,
  parameter int CNT_W = 12
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic             chain_mode,
  input  logic             encrypt,
  input  logic [LEN_W-1:0] blk_count,
  input  logic             key_req,
  input  logic             core_ready,
  output logic             core_go,
  output logic             core_key_load,
  output logic             core_chain,
  output logic             core_encrypt,
  output logic [LEN_W-1:0] blocks_left,
  output logic [CNT_W-1:0] pkt_count,
  output logic             busy,
  output logic             done
);
  localparam logic [CNT_W-1:0] PKT_MAX = {CNT_W{1'b1}};
  localparam logic [LEN_W-1:0] ONE     = LEN_W'(1);

  typedef enum logic [2:0] {S_IDLE, S_KEY, S_KWAIT, S_ISSUE, S_WAIT} st_t;
  st_t st;

  logic [CNT_W-1:0] pkt_next;
  assign pkt_next = (pkt_count == PKT_MAX) ? PKT_MAX : pkt_count + 1'b1;

  assign core_go       = (st == S_ISSUE);
  assign core_key_load = (st == S_KEY);
  assign busy          = (st != S_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      st           <= S_IDLE;
      blocks_left  <= '0;
      pkt_count    <= '0;
      done         <= 1'b0;
      core_chain   <= 1'b0;
      core_encrypt <= 1'b0;
    end else begin
      done <= 1'b0;
      unique case (st)
        S_IDLE: if (start) begin
          core_chain   <= chain_mode;
          core_encrypt <= encrypt;
          blocks_left  <= blk_count;
          if (blk_count == '0) begin
            done      <= 1'b1;
            pkt_count <= pkt_next;
          end else begin
            st <= key_req ? S_KEY : S_ISSUE;
          end
        end
        S_KEY:   st <= S_KWAIT;
        S_KWAIT: if (core_ready) st <= S_ISSUE;
        S_ISSUE: st <= S_WAIT;
        S_WAIT: if (core_ready) begin
          blocks_left <= blocks_left - ONE;
          if (blocks_left == ONE) begin
            done      <= 1'b1;
            pkt_count <= pkt_next;
            st        <= S_IDLE;
          end else begin
            st <= S_ISSUE;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/cipher_seq_ctrl_chk.sv
module cipher_seq_ctrl_chk #(
  parameter int LEN_W = 5,
  parameter int CNT_W = 12
) (
  input logic             clk,
  input logic             rst,
  input logic             start,
  input logic [LEN_W-1:0] blk_count,
  input logic             core_ready,
  input logic             core_go,
  input logic             core_key_load,
  input logic             core_chain,
  input logic             core_encrypt,
  input logic [LEN_W-1:0] blocks_left,
  input logic [CNT_W-1:0] pkt_count,
  input logic             busy,
  input logic             done
);
  localparam logic [CNT_W-1:0] PKT_MAX = {CNT_W{1'b1}};

  p_go_pulse_r5: assert property (@(posedge clk) disable iff (rst)
    core_go |=> !core_go);
  p_key_pulse_r4: assert property (@(posedge clk) disable iff (rst)
    core_key_load |=> !core_key_load);
  p_key_before_go_r4: assert property (@(posedge clk) disable iff (rst)
    core_key_load |=> !core_go);
  p_done_pulse_r7: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  p_done_idle_r7: assert property (@(posedge clk) disable iff (rst)
    done |-> (!busy && blocks_left == '0));
  p_pkt_hold_r8: assert property (@(posedge clk) disable iff (rst)
    !done |-> $stable(pkt_count));
  p_pkt_step_r8: assert property (@(posedge clk) disable iff (rst)
    done |-> ((pkt_count == CNT_W'($past(pkt_count) + 1'b1)) ||
              (pkt_count == PKT_MAX && $past(pkt_count) == PKT_MAX)));
  p_len_hold_r6: assert property (@(posedge clk) disable iff (rst)
    (busy && !core_ready) |=> $stable(blocks_left));
  p_cfg_hold_r3: assert property (@(posedge clk) disable iff (rst)
    busy |=> ($stable(core_chain) && $stable(core_encrypt)));
  p_zero_len_r9: assert property (@(posedge clk) disable iff (rst)
    (!busy && start && blk_count == '0) |=> (done && !core_go && !core_key_load));
endmodule

bind cipher_seq_ctrl cipher_seq_ctrl_chk #(.LEN_W(LEN_W), .CNT_W(CNT_W)) u_chk (.*);

// File: tb/sim_cipher_seq_ctrl.sv
`timescale 1ns/1ps
module sim_cipher_seq_ctrl;
  localparam int LAT = 3;
  logic clk = 1'b0, rst = 1'b1, start = 1'b0, chain_mode = 1'b0, encrypt = 1'b0, key_req = 1'b0;
  logic [4:0] blk_count = '0;
  logic core_ready, core_go, core_key_load, core_chain, core_encrypt, busy, done;
  logic [4:0] blocks_left;
  logic [11:0] pkt_count;
  logic [LAT-1:0] pipe = '0;
  int checks = 0, fails = 0, model = 0, cyc = 0;

  always #4 clk = ~clk;

  always @(posedge clk) pipe <= {pipe[LAT-2:0], core_go | core_key_load};
  assign core_ready = pipe[LAT-1];

  cipher_seq_ctrl u0 (.clk, .rst, .start, .chain_mode, .encrypt, .blk_count, .key_req,
    .core_ready, .core_go, .core_key_load, .core_chain, .core_encrypt,
    .blocks_left, .pkt_count, .busy, .done);

  function automatic int sat_inc(int v);
    return (v >= 4095) ? 4095 : v + 1;
  endfunction

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      checks++; fails++;
      $display("FAIL watchdog: actual %0d expected below 150000 cycles", cyc);
      summary();
    end
  end

  task automatic run_pkt(bit m, bit d, int len, bit key, bit stray);
    int gos = 0, keys = 0, n = 0, key_at = -1, first_go = -1;
    bit seen = 0;
    @(negedge clk);
    chain_mode = m; encrypt = d; blk_count = 5'(len); key_req = key; start = 1'b1;
    @(negedge clk);
    start = 1'b0; chain_mode = ~m; encrypt = ~d; key_req = ~key;
    while (!seen && n < 500) begin
      if (n > 0) @(negedge clk);
      n++;
      if (stray && n == 4) begin start = 1'b1; blk_count = 5'(len ^ 5'h0a); end
      if (stray && n == 5) start = 1'b0;
      if (core_key_load) begin keys++; key_at = n; end
      if (core_go) begin
        if (first_go < 0) first_go = n;
        chk("R6 blocks_left at go", blocks_left, len - gos);
        chk("R3 core_chain while busy", core_chain, m);
        chk("R3 core_encrypt while busy", core_encrypt, d);
        gos++;
      end
      if (done) seen = 1;
    end
    model = sat_inc(model);
    chk("R7 done seen", seen, 1);
    chk("R7 busy low at done", busy, 0);
    chk("R7 blocks_left zero at done", blocks_left, 0);
    chk("R8 pkt_count", pkt_count, model);
    if (len == 0) begin
      chk("R9 immediate done", n, 1);
      chk("R9 no go", gos, 0);
      chk("R9 no key load", keys, 0);
    end else begin
      chk(stray ? "R2 go count with stray start" : "R5 go count", gos, len);
      chk("R4 key load count", keys, key ? 1 : 0);
      if (key) chk("R4 key before go", (first_go > key_at + LAT) ? 1 : 0, 1);
    end
    @(negedge clk);
    chk("R7 done one cycle", done, 0);
    chk("R8 pkt_count held", pkt_count, model);
  endtask

  initial begin
    void'($urandom(32'd20240611));
    start = 1'b1; blk_count = 5'd7;
    repeat (4) @(negedge clk);
    rst = 1'b0; start = 1'b0;
    chk("R1 busy", busy, 0);
    chk("R1 blocks_left", blocks_left, 0);
    chk("R1 pkt_count", pkt_count, 0);
    chk("R1 done", done, 0);
    chk("R1 core_go", core_go, 0);
    chk("R1 core_key_load", core_key_load, 0);
    run_pkt(1, 1, 0, 1, 0);
    run_pkt(1, 1, 1, 0, 0);
    run_pkt(0, 0, 31, 1, 0);
    run_pkt(1, 0, 5, 1, 1);
    run_pkt(0, 1, 9, 0, 1);
    for (int i = 0; i < 40; i++)
      run_pkt(1'($urandom), 1'($urandom), int'($urandom % 32), 1'($urandom), 1'($urandom));
    while (model < 4095) run_pkt(1'($urandom), 1'($urandom), 0, 1'($urandom), 0);
    chk("R8 reached saturation", pkt_count, 4095);
    run_pkt(0, 1, 3, 0, 0);
    run_pkt(1, 0, 0, 0, 0);
    chk("R8 saturated", pkt_count, 4095);
    summary();
  end
endmodule